// File: doc/BRIEF.md
# Replicated Multi-Read-Port Memory

This block gives `N_RD` independent read ports into a small memory by holding `N_RD` identical copies of its contents. Each copy is a plain single-port array that serves exactly one read port. There is a single write port. Every write is broadcast to all copies in the same cycle, so the copies never drift apart. Because a copy has only one physical port, a cycle that writes the copies cannot serve any read, and the block signals this by lowering `rd_rdy_o` on all ports at once.

With `USE_WBUF=1`, a one-entry holding register takes each incoming write. The held write is retired into the copies in the first cycle that has no valid read and no new write. A read whose address matches the held entry is answered from it. A new write that arrives while the register is occupied forces the old entry out, and that cycle's reads are stalled. With `USE_WBUF=0`, writes go straight to the copies, and every write stalls the reads in its cycle.

A read is accepted when `rd_vld_i` and `rd_rdy_o` are both high. Its data appears one cycle later, qualified by `rd_dvld_o`.

Top module: `rep_rd_mem`

## Requirements
- R1: A read accepted in cycle t (valid and ready high) raises `rd_dvld_o` in cycle t+1, and its data equals the value most recently written to that address by a write presented in a cycle before t.
- R2: `rd_rdy_o` is the same on every port. When ready is high, all valid ports are served in the same cycle for any combination of addresses, including all ports reading one address.
- R3: A write reaches every copy, so after any traffic all ports return the same value for every address.
- R4: With `USE_WBUF=0`, `rd_rdy_o` is low in exactly those cycles where `wr_en_i` is high.
- R5: With `USE_WBUF=1`, a write arriving while the holding register is empty is captured without lowering `rd_rdy_o`. Reads in that cycle return the contents from before the write.
- R6: With `USE_WBUF=1`, a held write is retired in the first cycle with no valid read and no write, leaving the register empty. It stays held while reads keep arriving.
- R7: With `USE_WBUF=1`, a write arriving while the register holds an entry forces that entry into the copies, lowers `rd_rdy_o` on all ports in that cycle, and the new write takes the register.
- R8: A read whose address matches the held, unretired write returns the held data.
- R9: During and right after reset, `rd_rdy_o` is high on all ports (the register is empty) and `rd_dvld_o` is low.
- R10: A read that is not valid, or is valid but stalled, leaves `rd_dvld_o` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_vld_i | input | N_RD | Read request per port |
| rd_addr_i | input | N_RD x AW | Read address per port |
| rd_rdy_o | output | N_RD | Read accepted this cycle (low = stall) |
| rd_dvld_o | output | N_RD | Read data valid, one cycle after acceptance |
| rd_data_o | output | N_RD x DW | Read data per port |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data |

## Verification
The bench runs the buffered and unbuffered variants side by side and aims at four cases: a read right after a write to the same address, which exposes a missing bypass as stale data; back-to-back writes with reads, where a controller that fails to force the retirement would either lose the older write or serve reads on a busy copy; an idle cycle between writes, where a register that never drains would stall the next write needlessly; and a read in the same cycle as a captured write, which must return the old value. A closing sweep reads every address on all ports together. Any port whose copy missed a broadcast write shows up there as a mismatch.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  // what the single physical port of every copy does this cycle on the write side
  typedef enum logic [1:0] {WA_NONE, WA_DRAIN, WA_FORCE, WA_DIRECT} wr_act_e;
endpackage

// File: rtl/rrm_bank.sv
module rrm_bank #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // single port: write or read, never both
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o       <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/rrm_wctl.sv
module rrm_wctl
  import rrm_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 32,
  parameter bit USE_WBUF = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          any_rd_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          commit_o,
  output logic [AW-1:0] cm_addr_o,
  output logic [DW-1:0] cm_data_o,
  output logic          blk_o,
  output logic          buf_vld_o,
  output logic [AW-1:0] buf_addr_o,
  output logic [DW-1:0] buf_data_o
);
  if (USE_WBUF) begin : g_buf
    logic          vld_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    wr_act_e       act;

    always_comb begin
      act = WA_NONE;
      if (vld_q && wr_en_i)        act = WA_FORCE;
      else if (vld_q && !any_rd_i) act = WA_DRAIN;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q  <= 1'b0;
        addr_q <= '0;
        data_q <= '0;
      end else if (wr_en_i) begin
        vld_q  <= 1'b1;
        addr_q <= wr_addr_i;
        data_q <= wr_data_i;
      end else if (act == WA_DRAIN) begin
        vld_q  <= 1'b0;
      end
    end

    assign commit_o   = (act != WA_NONE);
    assign blk_o      = (act == WA_FORCE);
    assign cm_addr_o  = addr_q;
    assign cm_data_o  = data_q;
    assign buf_vld_o  = vld_q;
    assign buf_addr_o = addr_q;
    assign buf_data_o = data_q;
  end else begin : g_direct
    wr_act_e act;
    assign act        = wr_en_i ? WA_DIRECT : WA_NONE;
    assign commit_o   = (act == WA_DIRECT);
    assign blk_o      = (act == WA_DIRECT);
    assign cm_addr_o  = wr_addr_i;
    assign cm_data_o  = wr_data_i;
    assign buf_vld_o  = 1'b0;
    assign buf_addr_o = '0;
    assign buf_data_o = '0;
  end
endmodule

// File: rtl/rep_rd_mem.sv
module rep_rd_mem #(
  parameter int N_RD     = 2,
  parameter int DEPTH    = 16,
  parameter int DW       = 32,
  parameter bit USE_WBUF = 1'b1,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_RD-1:0]          rd_vld_i,
  input  logic [N_RD-1:0][AW-1:0]  rd_addr_i,
  output logic [N_RD-1:0]          rd_rdy_o,
  output logic [N_RD-1:0]          rd_dvld_o,
  output logic [N_RD-1:0][DW-1:0]  rd_data_o,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [DW-1:0]            wr_data_i
);
  logic          commit, blk, buf_vld;
  logic [AW-1:0] cm_addr, buf_addr;
  logic [DW-1:0] cm_data, buf_data, byp_q;
  logic [N_RD-1:0]         dvld_q, hit_q;
  logic [N_RD-1:0][DW-1:0] bank_q;

  rrm_wctl #(.AW(AW), .DW(DW), .USE_WBUF(USE_WBUF)) u_wctl (
    .clk_i, .rst_ni,
    .any_rd_i  (|rd_vld_i),
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .commit_o  (commit),
    .cm_addr_o (cm_addr),
    .cm_data_o (cm_data),
    .blk_o     (blk),
    .buf_vld_o (buf_vld),
    .buf_addr_o(buf_addr),
    .buf_data_o(buf_data)
  );

  for (genvar g = 0; g < N_RD; g++) begin : g_port
    assign rd_rdy_o[g] = ~blk;

    rrm_bank #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_bank (
      .clk_i,
      .en_i   (commit | rd_vld_i[g]),
      .we_i   (commit),
      .addr_i (commit ? cm_addr : rd_addr_i[g]),
      .wdata_i(cm_data),
      .rdata_o(bank_q[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dvld_q[g] <= 1'b0;
        hit_q[g]  <= 1'b0;
      end else begin
        dvld_q[g] <= rd_vld_i[g] & ~blk;
        hit_q[g]  <= rd_vld_i[g] & ~blk & buf_vld & (rd_addr_i[g] == buf_addr);
      end
    end

    assign rd_data_o[g] = hit_q[g] ? byp_q : bank_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byp_q <= '0;
    else         byp_q <= buf_data;
  end

  assign rd_dvld_o = dvld_q;
endmodule

// File: rtl/rrm_chk.sv
module rrm_chk #(
  parameter int N_RD     = 2,
  parameter bit USE_WBUF = 1'b1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_RD-1:0] rd_vld_i,
  input logic [N_RD-1:0] rd_rdy_o,
  input logic [N_RD-1:0] rd_dvld_o,
  input logic            wr_en_i,
  input logic            buf_vld_i
);
  for (genvar i = 0; i < N_RD; i++) begin : g_p
    p_accept_data_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_vld_i[i] && rd_rdy_o[i]) |=> rd_dvld_o[i]);
    p_stall_nodata_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rd_vld_i[i] && rd_rdy_o[i]) |=> !rd_dvld_o[i]);
  end

  p_common_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rdy_o == '0) || (rd_rdy_o == {N_RD{1'b1}}));

  if (USE_WBUF) begin : g_buf
    p_capture_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !buf_vld_i) |-> (rd_rdy_o == {N_RD{1'b1}}));
    p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> buf_vld_i);
    p_drain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (buf_vld_i && !wr_en_i && rd_vld_i == '0) |=> !buf_vld_i);
    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (buf_vld_i && !wr_en_i && rd_vld_i != '0) |=> buf_vld_i);
    p_force_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (buf_vld_i && wr_en_i) |-> (rd_rdy_o == '0));
  end else begin : g_nobuf
    p_write_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |-> (rd_rdy_o == '0));
    p_idle_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |-> (rd_rdy_o == {N_RD{1'b1}}));
  end
endmodule

bind rep_rd_mem rrm_chk #(.N_RD(N_RD), .USE_WBUF(USE_WBUF)) u_chk (
  .clk_i, .rst_ni, .rd_vld_i, .rd_rdy_o, .rd_dvld_o, .wr_en_i,
  .buf_vld_i(buf_vld)
);

// File: tb/sim_rep_rd_mem.sv
module sim_rep_rd_mem;
  localparam int CLK_P = 10;
  localparam int N = 2, DEPTH = 16, DW = 32, AW = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [N-1:0]         rd_vld = '0;
  logic [N-1:0][AW-1:0] rd_addr = '0;
  logic                 wr_en = 1'b0;
  logic [AW-1:0]        wr_addr = '0;
  logic [DW-1:0]        wr_data = '0;
  logic [N-1:0]         rdy0, dv0, rdy1, dv1;
  logic [N-1:0][DW-1:0] dat0, dat1;

  rep_rd_mem #(.N_RD(N), .DEPTH(DEPTH), .DW(DW), .USE_WBUF(1'b1)) u0 (
    .clk_i(clk), .rst_ni, .rd_vld_i(rd_vld), .rd_addr_i(rd_addr),
    .rd_rdy_o(rdy0), .rd_dvld_o(dv0), .rd_data_o(dat0),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data));
  rep_rd_mem #(.N_RD(N), .DEPTH(DEPTH), .DW(DW), .USE_WBUF(1'b0)) u1 (
    .clk_i(clk), .rst_ni, .rd_vld_i(rd_vld), .rd_addr_i(rd_addr),
    .rd_rdy_o(rdy1), .rd_dvld_o(dv1), .rd_data_o(dat1),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data));

  int n_tst = 0, n_fail = 0;
  logic [DW-1:0] mdl [DEPTH];
  bit            mb_v = 1'b0;
  logic [AW-1:0] mb_a = '0;
  bit            xdv0 [N];
  bit            xdv1 [N];
  logic [DW-1:0] xd [N];
  string         xtag [N];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tst++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_out();
    for (int i = 0; i < N; i++) begin
      chk(dv0[i] === xdv0[i], xdv0[i] ? "R1" : "R10", "u0 dvld", 64'(dv0[i]), 64'(xdv0[i]));
      chk(dv1[i] === xdv1[i], xdv1[i] ? "R1" : "R10", "u1 dvld", 64'(dv1[i]), 64'(xdv1[i]));
      if (xdv0[i]) chk(dat0[i] === xd[i], xtag[i], "u0 data", 64'(dat0[i]), 64'(xd[i]));
      if (xdv1[i]) chk(dat1[i] === xd[i], "R1", "u1 data", 64'(dat1[i]), 64'(xd[i]));
    end
  endtask

  task automatic cyc(input logic [N-1:0] v, input logic [N-1:0][AW-1:0] a,
                     input logic w, input logic [AW-1:0] wa, input logic [DW-1:0] wd);
    bit e0, e1;
    @(negedge clk);
    check_out();
    rd_vld = v; rd_addr = a; wr_en = w; wr_addr = wa; wr_data = wd;
    #1;
    e0 = !(mb_v && w);
    e1 = !w;
    for (int i = 0; i < N; i++) begin
      chk(rdy0[i] === e0, (mb_v && w) ? "R7" : (w ? "R5" : "R2"), "u0 rdy", 64'(rdy0[i]), 64'(e0));
      chk(rdy1[i] === e1, "R4", "u1 rdy", 64'(rdy1[i]), 64'(e1));
      xdv0[i] = v[i] && e0;
      xdv1[i] = v[i] && e1;
      xd[i]   = mdl[a[i]];
      xtag[i] = (mb_v && a[i] == mb_a) ? "R8" : "R1";
    end
    if (w) begin
      mdl[wa] = wd; mb_v = 1'b1; mb_a = wa;
    end else if (mb_v && v == '0) begin
      mb_v = 1'b0;   // R6 drain
    end
  endtask

  function automatic logic [N-1:0][AW-1:0] same_addr(input logic [AW-1:0] a);
    logic [N-1:0][AW-1:0] r;
    for (int i = 0; i < N; i++) r[i] = a;
    return r;
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL R1 watchdog expired act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_tst, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0][AW-1:0] aa;
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin xdv0[i] = 0; xdv1[i] = 0; xd[i] = '0; xtag[i] = "R1"; end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(rdy0 === '1 && rdy1 === '1, "R9", "rdy in reset", 64'({rdy0, rdy1}), 64'hf);
    chk(dv0 === '0 && dv1 === '0, "R9", "dvld in reset", 64'({dv0, dv1}), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rdy0 === '1 && dv0 === '0, "R9", "u0 after reset", 64'({rdy0, dv0}), 64'hc);

    // fill every address, no reads (back-to-back writes force retirement)
    for (int a = 0; a < DEPTH; a++) cyc('0, '0, 1'b1, AW'(a), $urandom);
    cyc('0, '0, 1'b0, '0, '0);

    // R8 bypass: write then read same address immediately on both ports
    cyc('0, '0, 1'b1, 4'd3, 32'hA5A5_0003);
    cyc('1, same_addr(4'd3), 1'b0, '0, '0);
    // R7 forced retirement with reads present
    aa[0] = 4'd3; aa[1] = 4'd7;
    cyc('1, aa, 1'b1, 4'd7, 32'h0000_7777);
    cyc('1, aa, 1'b0, '0, '0);
    // R6 drain, then R5 capture with reads returning old value
    cyc('0, '0, 1'b0, '0, '0);
    cyc('1, same_addr(4'd9), 1'b1, 4'd9, 32'h9999_0009);
    cyc('1, same_addr(4'd9), 1'b0, '0, '0);
    // R6 hold while reads continue, then drain
    aa[0] = 4'd1; aa[1] = 4'd2;
    cyc(2'b01, aa, 1'b0, '0, '0);
    cyc('0, '0, 1'b0, '0, '0);
    cyc('1, same_addr(4'd9), 1'b1, 4'd4, 32'h4444_0004);
    // R2 mixed addresses
    aa[0] = 4'd15; aa[1] = 4'd0;
    cyc('1, aa, 1'b0, '0, '0);

    // constrained random traffic
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < N; i++) aa[i] = AW'($urandom % DEPTH);
      cyc(N'($urandom), aa, ($urandom % 10) < 3, AW'($urandom % DEPTH), $urandom);
    end

    // R3 sweep: every port reads every address together
    cyc('0, '0, 1'b0, '0, '0);
    for (int a = 0; a < DEPTH; a++) cyc('1, same_addr(AW'(a)), 1'b0, '0, '0);
    cyc('0, '0, 1'b0, '0, '0);
    for (int a = 0; a < DEPTH; a++) begin
      cyc('1, same_addr(AW'(a)), 1'b0, '0, '0);
      @(negedge clk);
      chk(dat0[0] === dat0[N-1] && dat1[0] === dat1[N-1], "R3", "copies agree",
          64'(dat0[N-1]), 64'(dat0[0]));
      check_out();
      for (int i = 0; i < N; i++) begin xdv0[i] = 0; xdv1[i] = 0; end
      rd_vld = '0;
    end
    cyc('0, '0, 1'b0, '0, '0);
    cyc('0, '0, 1'b0, '0, '0);

    $display("[TB] %0d tests run, %0d failed", n_tst, n_fail);
    $finish;
  end
endmodule